// File: doc/BRIEF.md
# Third-Order CIC Interpolator

This block raises the sample rate of one signed 16-bit stream for a DAC sample path. It uses a cascaded integrator-comb structure of order three. Three difference stages run once per accepted input sample. A zero-order hold carries the difference result across the output-rate interval. Three running-sum stages then run once per output tick. The final sum is scaled down by an arithmetic right shift and clamped to the signed 16-bit range before it is registered at the output.

The upsampling factor is encoded as a 6-bit mantissa and a 4-bit exponent. The gain-compensation shift is 6 bits. All three live in one 16-bit configuration word. A write only stages the word. A separate apply strobe makes the staged word active, clears every filter state register and the phase counter, and restarts a settle window. During that window no output is produced until three input samples have been accepted. The output side is paced by an external `tick` strobe. The block asks for a new input sample on the first tick of each interval of R ticks.

Top module: `cic3_interp`

## Requirements
- R1: After reset the active setting is rate 1 with shift 0, `out_valid` and `out_data` are 0, and `in_ready` is 0 while `tick` is low.
- R2: The configuration word holds the rate mantissa minus one in bits [5:0], the rate exponent in bits [9:6] and the shift in bits [15:10]. The rate is R = (bits[5:0] + 1) << bits[9:6].
- R3: The filter sum is divided by 2 to the power of the shift field using an arithmetic right shift, which rounds toward minus infinity.
- R4: A shifted result above 32767 gives 32767, and one below -32768 gives -32768.
- R5: A write with `cfg_we` changes nothing in the output stream until `cfg_apply` is pulsed.
- R6: On a cycle with `cfg_apply` high, the staged word becomes active. All filter state, the phase counter and the settle count are cleared. A `tick` in that same cycle is ignored, so `in_ready` is 0 and no output follows.
- R7: After reset or apply, the ticks up to and including the one that accepts the third input sample produce no output. Every later processed tick produces one.
- R8: `in_ready` equals `tick` on the first tick of each group of R processed ticks and is 0 otherwise. `out_valid` pulses one cycle after a processed tick, and `out_data` holds its value between pulses.
- R9: A tick that arrives at the start of a group while `in_valid` is low is ignored. It produces no output and does not advance the phase.
- R10: At output tick n after apply, the unclamped result is the sum over k of h[k]·u[n−k]. Here u holds input sample j at index j·R and zero elsewhere, and h is a length-R box of ones convolved with itself four times, counting the zero-order hold. The DC gain is R³.
- R11: With rate 1 and shift 0, each output equals the input accepted on the same tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Stage `cfg_wdata` |
| cfg_wdata | input | 16 | Configuration word (shift, exponent, mantissa−1) |
| cfg_apply | input | 1 | Activate the staged word and clear the filter |
| tick | input | 1 | Output-rate strobe |
| in_valid | input | 1 | Input sample present |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Sample accepted this cycle when `in_valid` is high |
| out_valid | output | 1 | One-cycle pulse, new output sample |
| out_data | output | 16 | Signed output sample |

## Verification
A wrong difference or running-sum register shows up as wrong `out_data` on the first valid output after settling. The response has only 4R−3 taps, so any error in state or in the held value is visible within about four input intervals. A wrong phase or settle count shows up at once as `in_ready` or `out_valid` landing on the wrong tick. Shift and clamp faults appear on the first sample whose scaled value is not exact or goes past the 16-bit range.

// File: rtl/cic3_pkg.sv
package cic3_pkg;
  localparam int DW     = 16;
  localparam int MANT_W = 6;
  localparam int EXP_W  = 4;
  localparam int GAIN_W = 6;
  localparam int ORDER  = 3;
  localparam int CFG_W  = MANT_W + EXP_W + GAIN_W;
  // widest rate: (2^MANT_W) << (2^EXP_W - 1)
  localparam int RATE_W = MANT_W + 1 + (1 << EXP_W) - 1;
  // growth of R^ORDER on top of the sample width
  localparam int ACC_W  = DW + ORDER * RATE_W;
  localparam int NS_W   = $clog2(ORDER + 1);

  typedef struct packed {
    logic [GAIN_W-1:0] shift;
    logic [EXP_W-1:0]  rexp;
    logic [MANT_W-1:0] mant_m1;
  } cic_cfg_t;
endpackage

// File: rtl/cic3_cfg.sv
module cic3_cfg
  import cic3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cfg_apply,
  output logic [RATE_W-1:0] rate,
  output logic [GAIN_W-1:0] shift
);
  cic_cfg_t stage_q, stage_d;
  cic_cfg_t act_q, act_d;
  logic [RATE_W-1:0] base;

  always_comb begin
    stage_d = stage_q;
    if (cfg_we) stage_d = cic_cfg_t'(cfg_wdata);
    act_d = act_q;
    if (cfg_apply) act_d = stage_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      act_q   <= '0;
    end else begin
      stage_q <= stage_d;
      act_q   <= act_d;
    end
  end

  assign base  = RATE_W'(act_q.mant_m1) + RATE_W'(1);
  assign rate  = base << act_q.rexp;
  assign shift = act_q.shift;

  // staged word reaches the active register only through apply
  assert_apply_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |=> act_q == $past(stage_q));
  assert_no_apply_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_apply |=> $stable(act_q));
endmodule

// File: rtl/cic3_seq.sv
module cic3_seq
  import cic3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              in_valid,
  input  logic              apply,
  input  logic [RATE_W-1:0] rate,
  output logic              in_ready,
  output logic              take,
  output logic              adv,
  output logic              out_en
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic [NS_W-1:0]   ns_q, ns_d;
  logic              at_start, at_end;

  assign at_start = (cnt_q == '0);
  assign at_end   = (cnt_q == rate - RATE_W'(1));
  assign in_ready = tick & at_start & ~apply;
  assign take     = in_ready & in_valid;
  assign adv      = tick & ~apply & (~at_start | in_valid);
  assign out_en   = (ns_q == NS_W'(ORDER));

  always_comb begin
    cnt_d = cnt_q;
    ns_d  = ns_q;
    if (apply) begin
      cnt_d = '0;
      ns_d  = '0;
    end else begin
      if (adv) cnt_d = at_end ? '0 : cnt_q + RATE_W'(1);
      if (take && !out_en) ns_d = ns_q + NS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ns_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      ns_q  <= ns_d;
    end
  end

  assert_apply_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (cnt_q == '0) && (ns_q == '0));
  assert_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_start && !in_valid && !apply) |=> $stable(cnt_q) && $stable(ns_q));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !apply) |=> $stable(cnt_q));
  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && at_end) |=> cnt_q == '0);
endmodule

// File: rtl/cic3_comb.sv
module cic3_comb
  import cic3_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    apply,
  input  logic                    take,
  input  logic signed [DW-1:0]    x,
  output logic signed [ACC_W-1:0] u
);
  logic signed [ACC_W-1:0] st [ORDER+1];
  logic signed [ACC_W-1:0] d_q [ORDER];
  logic signed [ACC_W-1:0] hold_q, hold_d;

  assign st[0] = ACC_W'(x);

  for (genvar k = 0; k < ORDER; k++) begin : g_diff
    logic signed [ACC_W-1:0] d_d;
    assign st[k+1] = st[k] - d_q[k];
    always_comb begin
      d_d = d_q[k];
      if (apply)     d_d = '0;
      else if (take) d_d = st[k];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) d_q[k] <= '0;
      else        d_q[k] <= d_d;
    end
    assert_diff_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> d_q[k] == '0);
  end

  always_comb begin
    hold_d = hold_q;
    if (apply)     hold_d = '0;
    else if (take) hold_d = st[ORDER];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  // zero-order hold between the low-rate and high-rate sections
  assign u = take ? st[ORDER] : hold_q;

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !apply) |=> $stable(hold_q));
endmodule

// File: rtl/cic3_integ.sv
module cic3_integ
  import cic3_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    apply,
  input  logic                    adv,
  input  logic signed [ACC_W-1:0] u,
  output logic signed [ACC_W-1:0] y
);
  logic signed [ACC_W-1:0] s [ORDER+1];
  logic signed [ACC_W-1:0] a_q [ORDER];

  assign s[0] = u;

  for (genvar k = 0; k < ORDER; k++) begin : g_acc
    logic signed [ACC_W-1:0] a_d;
    assign s[k+1] = a_q[k] + s[k];
    always_comb begin
      a_d = a_q[k];
      if (apply)    a_d = '0;
      else if (adv) a_d = s[k+1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) a_q[k] <= '0;
      else        a_q[k] <= a_d;
    end
    assert_acc_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> a_q[k] == '0);
    assert_acc_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !apply) |=> $stable(a_q[k]));
  end

  assign y = s[ORDER];
endmodule

// File: rtl/cic3_outstage.sv
module cic3_outstage
  import cic3_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic signed [ACC_W-1:0] y,
  input  logic [GAIN_W-1:0]       shift,
  output logic                    out_valid,
  output logic signed [DW-1:0]    out_data
);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [ACC_W-1:0] scaled;
  logic signed [DW-1:0]    clamped;
  logic                    vld_d;
  logic signed [DW-1:0]    dat_d;

  assign scaled = y >>> shift;

  always_comb begin
    if (scaled > MAXV)      clamped = MAXV[DW-1:0];
    else if (scaled < MINV) clamped = MINV[DW-1:0];
    else                    clamped = scaled[DW-1:0];
  end

  always_comb begin
    vld_d = fire;
    dat_d = out_data;
    if (fire) dat_d = clamped;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= vld_d;
      out_data  <= dat_d;
    end
  end

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(out_data));
  assert_clamp_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && scaled > MAXV) |=> out_data == MAXV[DW-1:0]);
  assert_clamp_bot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && scaled < MINV) |=> out_data == MINV[DW-1:0]);
endmodule

// File: rtl/cic3_interp.sv
module cic3_interp
  import cic3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              cfg_apply,
  input  logic              tick,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [DW-1:0]     out_data
);
  logic [RATE_W-1:0]       rate;
  logic [GAIN_W-1:0]       shift;
  logic                    take, adv, out_en;
  logic signed [ACC_W-1:0] u, y;
  logic signed [DW-1:0]    odata;

  cic3_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_apply(cfg_apply), .rate(rate), .shift(shift)
  );

  cic3_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid),
    .apply(cfg_apply), .rate(rate), .in_ready(in_ready), .take(take),
    .adv(adv), .out_en(out_en)
  );

  cic3_comb u_comb (
    .clk(clk), .rst_n(rst_n), .apply(cfg_apply), .take(take),
    .x($signed(in_data)), .u(u)
  );

  cic3_integ u_integ (
    .clk(clk), .rst_n(rst_n), .apply(cfg_apply), .adv(adv), .u(u), .y(y)
  );

  cic3_outstage u_out (
    .clk(clk), .rst_n(rst_n), .fire(adv & out_en), .y(y), .shift(shift),
    .out_valid(out_valid), .out_data(odata)
  );

  assign out_data = odata;

  assert_out_after_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(tick));
  assert_apply_mutes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_apply |=> !out_valid);
  assert_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !out_en) |=> !out_valid);
endmodule

// File: tb/tb_cic3_interp.sv
module tb_cic3_interp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we, cfg_apply, tick, in_valid;
  logic [15:0] cfg_wdata, in_data;
  logic        in_ready, out_valid;
  logic [15:0] out_data;

  int checks = 0;
  int fails  = 0;

  int     R, G, n, ph, taken;
  longint xs [0:63];
  longint h  [0:63];
  int     hlen;

  always #(CLK_PERIOD/2) clk = ~clk;

  cic3_interp dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_apply(cfg_apply), .tick(tick), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // h = box(R) convolved four times (three stages plus the hold), R10
  task automatic build_h();
    longint t [0:63];
    h[0] = 1;
    hlen = 1;
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < hlen + R - 1; k++) begin
        t[k] = 0;
        for (int i = 0; i < R; i++)
          if (k - i >= 0 && k - i < hlen) t[k] += h[k-i];
      end
      hlen = hlen + R - 1;
      for (int k = 0; k < hlen; k++) h[k] = t[k];
    end
  endtask

  function automatic longint model_y(input int nn);
    longint acc = 0;
    for (int k = 0; k < hlen; k++) begin
      int m = nn - k;
      if (m >= 0 && (m % R) == 0 && (m / R) < taken) acc += h[k] * xs[m / R];
    end
    acc = acc >>> G;
    if (acc > 32767)  acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  function automatic longint sample(input int j, input int mode);
    if (mode == 1) return (j < 6) ? 64'sd12000 : -64'sd12000;
    return longint'(((j * 12345 + mode * 6789 + 1000) % 65536) - 32768);
  endfunction

  task automatic step(input bit tk, input bit vl, input int mode, input string req);
    bit     exp_rdy, exp_vld, settled;
    longint ey = 0;
    longint xv;
    @(negedge clk);
    xv       = sample(taken, mode);
    tick     = tk;
    in_valid = vl;
    in_data  = 16'(xv);
    #1;
    exp_rdy = tk && (ph == 0);
    chk(in_ready == exp_rdy, "R8 in_ready", longint'(in_ready), longint'(exp_rdy));
    exp_vld = 1'b0;
    if (tk && (ph != 0 || vl)) begin
      settled = (taken >= 3);
      if (ph == 0) begin
        xs[taken] = xv;
        taken++;
      end
      exp_vld = settled;
      ey = model_y(n);
      n++;
      ph = (ph + 1) % R;
    end
    @(posedge clk);
    #1;
    if (tk && exp_rdy && !vl)
      chk(out_valid == 1'b0, "R9 stalled tick", longint'(out_valid), 0);
    else
      chk(out_valid == exp_vld, "R7 out_valid", longint'(out_valid), longint'(exp_vld));
    if (exp_vld)
      chk($signed(out_data) == ey, req, longint'($signed(out_data)), ey);
  endtask

  task automatic run(input int slots, input int mode, input string req);
    for (int i = 0; i < slots; i++)
      step((i % 3) != 1, (i % 11) != 5, mode, req);
    @(negedge clk);
    tick = 1'b0;
    in_valid = 1'b0;
  endtask

  // field layout R2: shift [15:10], exponent [9:6], mantissa-1 [5:0]
  task automatic apply_cfg(input int m1, input int e, input int g);
    @(negedge clk);
    cfg_wdata = 16'((g << 10) | (e << 6) | m1);
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_apply = 1'b1;
    tick      = 1'b1;
    in_valid  = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R6 tick ignored on apply", longint'(in_ready), 0);
    @(posedge clk);
    #1;
    chk(out_valid == 1'b0, "R6 no output on apply", longint'(out_valid), 0);
    @(negedge clk);
    cfg_apply = 1'b0;
    tick      = 1'b0;
    in_valid  = 1'b0;
    R = (m1 + 1) << e;
    G = g;
    n = 0; ph = 0; taken = 0;
    build_h();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_apply = 1'b0; tick = 1'b0; in_valid = 1'b0;
    cfg_wdata = '0; in_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0, "R1 reset out_valid", longint'(out_valid), 0);
    chk(out_data == 16'd0, "R1 reset out_data", longint'(out_data), 0);
    chk(in_ready == 1'b0, "R1 reset in_ready", longint'(in_ready), 0);

    // defaults after reset: rate 1, shift 0 (R1, R11)
    R = 1; G = 0; n = 0; ph = 0; taken = 0;
    build_h();
    run(24, 0, "R11 pass-through");

    // staged but not applied (R5)
    @(negedge clk);
    cfg_wdata = 16'((3 << 10) | 1);
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    run(15, 0, "R5 staged word inert");

    // sweep of rate encodings and shifts (R2, R3, R10)
    apply_cfg(1, 0, 3);  run(36,  2, "R2 R10 rate 2");
    apply_cfg(2, 0, 5);  run(54,  3, "R3 R10 rate 3 inexact shift");
    apply_cfg(0, 2, 6);  run(72,  4, "R2 rate 4 via exponent");
    apply_cfg(1, 1, 6);  run(72,  5, "R2 rate 4 via mantissa");
    apply_cfg(6, 0, 9);  run(126, 6, "R3 R10 rate 7");
    apply_cfg(3, 1, 9);  run(144, 7, "R2 R10 rate 8");
    apply_cfg(0, 0, 0);  run(24,  8, "R11 pass-through after apply");
    // saturation (R4): DC gain 8 with no shift
    apply_cfg(1, 0, 0);  run(36,  1, "R4 clamp");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule